// File: doc/BRIEF.md
# Byte-Serial Word Swap Register

This block holds one word of storage and exchanges it atomically with a word delivered one byte at a time. A requester raises the input valid bit with the lowest byte of a new word on the byte bus. It then supplies the other three bytes on the three cycles that follow. The block assembles the word and copies the stored word into a holding register. It then writes the new word into storage and returns the previous contents on a byte-wide output, lowest byte first, under an output valid bit.

The schedule is fixed and there is no backpressure. Output valid rises on the sixth clock edge after the edge that took the first input byte and stays high for four cycles. Until that output burst has ended, a new exchange cannot start. The block suits small semaphore, mailbox or swap registers that sit behind narrow serial links.

Top module: `swx_top`

## Requirements
- R1: While reset is asserted and after it is released, out_vld is 0 and out_dat is 0. The stored word is cleared to zero by reset, so the first exchange after reset returns 0x00000000.
- R2: An exchange starts on a clock edge at which in_vld is 1 while the block is idle. That edge takes byte 0 from in_dat. Bytes 1, 2 and 3 are taken on the next three edges, whatever in_vld is on those edges.
- R3: Input byte i (i = 0..3) lands in bits [8*i+7:8*i] of the assembled word, so the first byte is the least significant.
- R4: out_vld rises after the 6th clock edge counted from the edge that took input byte 0. It stays high for exactly 4 cycles and then falls.
- R5: While out_vld is high, out_dat carries the word that was stored before the exchange, as byte 0 then byte 1, byte 2 and byte 3, one byte per cycle.
- R6: The assembled word replaces the stored word, so the next exchange returns it. A transaction leaves storage unchanged except by its own write.
- R7: From the edge that starts an exchange up to and including the edge that clears out_vld, in_vld and in_dat have no effect beyond the three further bytes taken under R2. No second exchange starts inside that window.
- R8: out_dat is 0 in every cycle in which out_vld is 0.
- R9: Asserting reset in the middle of an exchange abandons it. No output burst follows, and storage reads back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside |
| in_vld | input | 1 | Starts an exchange when seen high while idle |
| in_dat | input | 8 | Incoming word byte, least significant first |
| out_vld | output | 1 | High for the four cycles of returned bytes |
| out_dat | output | 8 | Returned byte of the previous stored word, zero when idle |

## Verification
Almost any internal fault here becomes visible at the ports within one exchange. A lane select that is wrong in the assembler, or a holding copy taken at the wrong time, shows up as a permuted or stale byte. The fault may surface in the burst of the same exchange, or in the burst of the following one, because storage is only observable through the next swap. An error in the sequencer shows up as an output burst that starts a cycle early or late, or that has the wrong length. A restart that should have been ignored produces an extra burst. The bench therefore runs chains of exchanges with distinct byte patterns, holds in_vld high through the busy window, and watches idle gaps for stray valid cycles.

// File: rtl/swx_pkg.sv
package swx_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_BYTES = 4;
  localparam int unsigned WORD_W  = BYTE_W * N_BYTES;
  localparam int unsigned IDX_W   = $clog2(N_BYTES);

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_GATHER = 3'd1,
    ST_SNAP   = 3'd2,
    ST_COMMIT = 3'd3,
    ST_EMIT   = 3'd4,
    ST_DRAIN  = 3'd5
  } swx_state_e;
endpackage

// File: rtl/swx_gather.sv
module swx_gather
  import swx_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned NB = N_BYTES,
  localparam int unsigned WW = BW * NB,
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [IW-1:0] cap_idx,
  input  logic [BW-1:0] in_dat,
  output logic [WW-1:0] word
);
  logic [NB-1:0] lane_en;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_en[g] = cap_en && (cap_idx == IW'(g));

    logic [BW-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (lane_en[g]) begin
        lane_q <= in_dat;
      end
    end
    assign word[g*BW +: BW] = lane_q;
  end

  // R3: a captured byte appears in exactly one lane, at its index
  a_r3_one_lane : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_en));
  a_r3_lane_pos : assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && cap_idx == '0) |=> word[BW-1:0] == $past(in_dat));
endmodule

// File: rtl/swx_ctrl.sv
module swx_ctrl
  import swx_pkg::*;
#(
  parameter int unsigned NB = N_BYTES,
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1,
  localparam logic [IW-1:0] LAST = IW'(NB - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  output logic          cap_en,
  output logic [IW-1:0] cap_idx,
  output logic          snap_en,
  output logic          commit_en,
  output logic          emit_en,
  output logic [IW-1:0] emit_idx
);
  swx_state_e    state_q, state_d;
  logic [IW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    cap_en    = 1'b0;
    cap_idx   = cnt_q;
    snap_en   = 1'b0;
    commit_en = 1'b0;
    emit_en   = 1'b0;
    emit_idx  = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        cap_idx = '0;
        if (in_vld) begin
          cap_en  = 1'b1;
          cnt_d   = IW'(1);
          state_d = (NB == 1) ? ST_SNAP : ST_GATHER;
        end
      end
      ST_GATHER: begin
        cap_en = 1'b1;
        if (cnt_q == LAST) begin
          cnt_d   = '0;
          state_d = ST_SNAP;
        end else begin
          cnt_d = cnt_q + IW'(1);
        end
      end
      ST_SNAP: begin
        snap_en = 1'b1;
        state_d = ST_COMMIT;
      end
      ST_COMMIT: begin
        commit_en = 1'b1;
        cnt_d     = '0;
        state_d   = ST_EMIT;
      end
      ST_EMIT: begin
        emit_en = 1'b1;
        if (cnt_q == LAST) begin
          cnt_d   = '0;
          state_d = ST_DRAIN;
        end else begin
          cnt_d = cnt_q + IW'(1);
        end
      end
      ST_DRAIN: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R2: the gather phase runs its full length, then the snapshot follows
  a_r2_gather_end : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GATHER && cnt_q == LAST) |=> state_q == ST_SNAP);
  // R7: the output phase never hands over straight to a new gather
  a_r7_no_restart : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EMIT || state_q == ST_DRAIN) |=> state_q != ST_GATHER);
  // R4: the write is followed directly by the output phase
  a_r4_commit_emit : assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> emit_en);
endmodule

// File: rtl/swx_vault.sv
module swx_vault
  import swx_pkg::*;
#(
  parameter int unsigned WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snap_en,
  input  logic          commit_en,
  input  logic [WW-1:0] new_word,
  output logic [WW-1:0] old_word
);
  logic [WW-1:0] store_q, store_d;
  logic [WW-1:0] hold_q, hold_d;

  always_comb begin
    store_d = store_q;
    hold_d  = hold_q;
    if (snap_en)   hold_d  = store_q;
    if (commit_en) store_d = new_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      hold_q  <= '0;
    end else begin
      store_q <= store_d;
      hold_q  <= hold_d;
    end
  end

  assign old_word = hold_q;

  // R6: storage changes only on the write step
  a_r6_store_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !commit_en |=> $stable(store_q));
  // R5: the holding copy keeps the pre-write value through the write
  a_r5_hold_stable : assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> $stable(hold_q));
endmodule

// File: rtl/swx_emit.sv
module swx_emit
  import swx_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned NB = N_BYTES,
  localparam int unsigned WW = BW * NB,
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          emit_en,
  input  logic [IW-1:0] emit_idx,
  input  logic [WW-1:0] word,
  output logic          out_vld,
  output logic [BW-1:0] out_dat
);
  logic [BW-1:0] lanes [NB];
  logic [BW-1:0] pick;
  logic          vld_d;
  logic [BW-1:0] dat_d;

  for (genvar g = 0; g < NB; g++) begin : g_slice
    assign lanes[g] = word[g*BW +: BW];
  end

  always_comb begin
    pick = lanes[0];
    for (int k = 0; k < NB; k++) begin
      if (emit_idx == IW'(k)) pick = lanes[k];
    end
    vld_d = emit_en;
    dat_d = emit_en ? pick : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_dat <= '0;
    end else begin
      out_vld <= vld_d;
      out_dat <= dat_d;
    end
  end

  // R8: the byte bus is quiet whenever valid is low
  a_r8_zero_idle : assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> out_dat == '0);
  // R5: the first returned byte is the low byte of the held word
  a_r5_first_byte : assert property (@(posedge clk) disable iff (!rst_n)
    (emit_en && emit_idx == '0) |=> out_dat == $past(word[BW-1:0]));
endmodule

// File: rtl/swx_top.sv
module swx_top
  import swx_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned NB = N_BYTES,
  localparam int unsigned WW = BW * NB,
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1,
  localparam int unsigned RW = $clog2(NB + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [BW-1:0] in_dat,
  output logic          out_vld,
  output logic [BW-1:0] out_dat
);
  logic [1:0]    rst_sync_q;
  logic          rst_sn;
  logic          cap_en, snap_en, commit_en, emit_en;
  logic [IW-1:0] cap_idx, emit_idx;
  logic [WW-1:0] new_word, old_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  swx_ctrl #(.NB(NB)) ctrl_i (
    .clk(clk), .rst_n(rst_sn), .in_vld(in_vld),
    .cap_en(cap_en), .cap_idx(cap_idx), .snap_en(snap_en),
    .commit_en(commit_en), .emit_en(emit_en), .emit_idx(emit_idx)
  );

  swx_gather #(.BW(BW), .NB(NB)) gather_i (
    .clk(clk), .rst_n(rst_sn), .cap_en(cap_en), .cap_idx(cap_idx),
    .in_dat(in_dat), .word(new_word)
  );

  swx_vault #(.WW(WW)) vault_i (
    .clk(clk), .rst_n(rst_sn), .snap_en(snap_en), .commit_en(commit_en),
    .new_word(new_word), .old_word(old_word)
  );

  swx_emit #(.BW(BW), .NB(NB)) emit_i (
    .clk(clk), .rst_n(rst_sn), .emit_en(emit_en), .emit_idx(emit_idx),
    .word(old_word), .out_vld(out_vld), .out_dat(out_dat)
  );

  // checking aid: length of the current output valid run
  logic [RW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      run_q <= '0;
    else if (out_vld) run_q <= (run_q == RW'(NB + 1)) ? run_q : run_q + RW'(1);
    else              run_q <= '0;
  end

  // R4: every output burst lasts exactly NB cycles
  a_r4_burst_len : assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(out_vld) |-> run_q == RW'(NB));
  a_r4_burst_max : assert property (@(posedge clk) disable iff (!rst_sn)
    run_q <= RW'(NB));
  // R1: held in reset, both outputs stay low
  always_comb begin
    if (!rst_sn) begin
      a_r1_reset_quiet : assert (out_vld == 1'b0 && out_dat == '0 || !$isunknown(rst_n) && rst_n);
    end
  end
endmodule

// File: tb/swx_top_tb_top.sv
module swx_top_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_vld;
  logic [7:0] in_dat;
  logic       out_vld;
  logic [7:0] out_dat;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  swx_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_dat(in_dat),
    .out_vld(out_vld), .out_dat(out_dat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R2 R3 R4 R5 R7 R8: one full exchange, sampled on falling edges
  task automatic xchg(input logic [31:0] nw, input logic [31:0] old, input bit busy_hold);
    @(negedge clk);
    in_vld = 1'b1;
    in_dat = nw[7:0];
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      in_vld = busy_hold;
      in_dat = nw[8*k +: 8];
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_vld = busy_hold;
      in_dat = busy_hold ? 8'h5A ^ 8'(k) : 8'h00;
      chk("R4 quiet before burst", {31'd0, out_vld}, 32'd0);
      chk("R8 zero data before burst", {24'd0, out_dat}, 32'd0);
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_dat = busy_hold ? 8'hC3 + 8'(k) : 8'h00;
      chk("R4 valid in burst", {31'd0, out_vld}, 32'd1);
      chk("R5 returned byte", {24'd0, out_dat}, {24'd0, old[8*k +: 8]});
    end
    @(negedge clk);
    in_vld = 1'b0;
    in_dat = 8'h00;
    chk("R4 valid falls after 4", {31'd0, out_vld}, 32'd0);
    chk("R8 zero data after burst", {24'd0, out_dat}, 32'd0);
  endtask

  // R7 R8: no stray burst for n cycles
  task automatic quiet(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk("R7 no stray valid", {31'd0, out_vld}, 32'd0);
      chk("R8 idle data zero", {24'd0, out_dat}, 32'd0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset valid", {31'd0, out_vld}, 32'd0);
    chk("R1 reset data", {24'd0, out_dat}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid after release", {31'd0, out_vld}, 32'd0);
  endtask

  initial begin
    rst_n  = 1'b0;
    in_vld = 1'b0;
    in_dat = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'd0, out_vld}, 32'd0);
    chk("R1 data in reset", {24'd0, out_dat}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R6: first exchange returns the cleared word
    xchg(32'h4433_2211, 32'h0000_0000, 1'b0);
    // R3 R6: second returns the first, lanes distinct
    xchg(32'hDEAD_BEEF, 32'h4433_2211, 1'b0);
    quiet(5);
    // R7: valid held high through the busy window
    xchg(32'h0102_0304, 32'hDEAD_BEEF, 1'b1);
    quiet(12);
    // R2: back to back, no idle gap
    xchg(32'hFF00_80A5, 32'h0102_0304, 1'b0);
    xchg(32'h7E6D_5C4B, 32'hFF00_80A5, 1'b0);

    // R9: reset in mid-gather abandons the exchange
    @(negedge clk);
    in_vld = 1'b1;
    in_dat = 8'h99;
    @(negedge clk);
    in_vld = 1'b0;
    in_dat = 8'h88;
    rst_n  = 1'b0;
    @(negedge clk);
    chk("R9 reset kills valid", {31'd0, out_vld}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    quiet(12);
    xchg(32'h1234_5678, 32'h0000_0000, 1'b0);

    do_reset();
    xchg(32'hA1B2_C3D4, 32'h0000_0000, 1'b0);
    xchg(32'h0000_0000, 32'hA1B2_C3D4, 1'b0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule